// File: doc/BRIEF.md
# Serial Control Register Write Port

This block holds a five-bit control word that a host loads over a three-wire synchronous serial link. The link has a serial clock, an active-low frame strobe and a serial data line. All three are brought into the system clock domain by synchronisers. The block counts falling serial-clock edges while the frame strobe is low and captures the first five data bits, most significant first.

The word is committed on the sixth falling edge. At that point the block updates its outputs and raises a one-cycle write strobe. The outputs are the three-bit channel address, a conversion-control bit and a standby flag.

Standby is applied later than the rest of the word, on the seventh falling edge. A frame that ends early changes nothing, with one exception: when the conversion bit has already arrived as 1, a one-cycle conversion request is still raised as the frame closes. Downstream conversion timing and the input multiplexer take the address and the request pulses from this block.

Top module: `ctl_wr_port`

## Requirements
- R1: After reset, the channel address, the conversion-control bit, the standby flag, the write strobe and the conversion request are all 0.
- R2: Data is sampled on falling serial-clock edges while the frame strobe is low. The first bit is address bit 2, the second is address bit 1, the third is address bit 0, the fourth is the conversion bit and the fifth is the standby bit.
- R3: On the sixth falling edge of a frame, the address and conversion-control outputs take the captured values, and `wr_strobe_o` is high for exactly one system clock.
- R4: A frame whose strobe rises before the sixth falling edge leaves the address, conversion-control and standby outputs unchanged and produces no write strobe.
- R5: A committed standby bit of 1 sets `standby_o` only on the seventh falling edge. A six-edge frame with the standby bit at 1 leaves `standby_o` unchanged.
- R6: A committed standby bit of 0 clears `standby_o` at the commit.
- R7: A committed word with the conversion bit at 1 gives exactly one one-cycle pulse on `conv_req_o`. A committed word with the conversion bit at 0 gives none.
- R8: A frame that ends after four or five falling edges, with the fourth bit at 1, gives one `conv_req_o` pulse and no register update.
- R9: Data on the sixth and later edges is not stored, and edges after the seventh have no effect.
- R10: The edge count restarts in every frame, so a short frame does not count towards the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| frame_ni | input | 1 | Frame strobe, active low |
| sdata_i | input | 1 | Serial data |
| chan_addr_o | output | 3 | Committed channel address |
| conv_ctl_o | output | 1 | Committed conversion-control bit |
| standby_o | output | 1 | Standby flag |
| wr_strobe_o | output | 1 | One-cycle pulse on each commit |
| conv_req_o | output | 1 | One-cycle conversion request |

## Verification
An edge counter that is off by one shifts the captured bits, so the next committed address or conversion bit is wrong when its strobe arrives. It can also commit a frame that should have been dropped, which gives an extra strobe within a few system clocks of the sixth edge.

A counter that is not cleared between frames makes a later short frame commit. Standby applied at the wrong edge shows as a wrong `standby_o` level once the frame has closed. A mishandled early abort shows as a missing or extra conversion pulse, counted at the end of that frame.

// File: rtl/ctl_wr_pkg.sv
package ctl_wr_pkg;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned REG_W       = ADDR_W + 2;
  localparam int unsigned CONV_EDGE   = ADDR_W + 1;
  localparam int unsigned COMMIT_EDGE = REG_W + 1;
  localparam int unsigned STBY_EDGE   = COMMIT_EDGE + 1;
  localparam int unsigned CNT_W       = $clog2(STBY_EDGE + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              conv;
    logic              stby;
  } ctl_word_t;
endpackage

// File: rtl/ctl_wr_sync.sv
module ctl_wr_sync #(
  parameter int unsigned       WIDTH   = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_wr_deser.sv
module ctl_wr_deser
  import ctl_wr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sclk_i,
  input  logic      frame_ni,
  input  logic      sdata_i,
  output ctl_word_t word_o,
  output logic      commit_o,
  output logic      stby_edge_o,
  output logic      abort_conv_o
);
  logic             sclk_q, frame_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] shreg_q;
  logic             fall, active, frame_end, conv_seen;

  assign active    = !frame_ni;
  assign fall      = sclk_q && !sclk_i && active;
  assign frame_end = !frame_q && frame_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b1;
      frame_q <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sclk_q  <= sclk_i;
      frame_q <= frame_ni;
      if (!active) cnt_q <= '0;
      else if (fall && cnt_q != CNT_W'(STBY_EDGE)) cnt_q <= cnt_q + 1'b1;
      if (fall && cnt_q < CNT_W'(REG_W)) shreg_q <= {shreg_q[REG_W-2:0], sdata_i};
    end
  end

  // conversion bit sits at shreg[0] after 4 edges, shreg[1] after 5
  assign conv_seen = (cnt_q == CNT_W'(CONV_EDGE)     && shreg_q[0]) ||
                     (cnt_q == CNT_W'(CONV_EDGE + 1) && shreg_q[1]);

  assign word_o       = ctl_word_t'(shreg_q);
  assign commit_o     = fall && cnt_q == CNT_W'(COMMIT_EDGE - 1);
  assign stby_edge_o  = fall && cnt_q == CNT_W'(STBY_EDGE - 1);
  assign abort_conv_o = frame_end && conv_seen;
endmodule

// File: rtl/ctl_wr_regs.sv
module ctl_wr_regs
  import ctl_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_word_t         word_i,
  input  logic              commit_i,
  input  logic              stby_edge_i,
  input  logic              abort_conv_i,
  output logic [ADDR_W-1:0] chan_addr_o,
  output logic              conv_ctl_o,
  output logic              standby_o,
  output logic              wr_strobe_o,
  output logic              conv_req_o
);
  logic stby_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_addr_o <= '0;
      conv_ctl_o  <= 1'b0;
      stby_bit_q  <= 1'b0;
      standby_o   <= 1'b0;
      wr_strobe_o <= 1'b0;
      conv_req_o  <= 1'b0;
    end else begin
      wr_strobe_o <= commit_i;
      conv_req_o  <= (commit_i && word_i.conv) || abort_conv_i;
      if (commit_i) begin
        chan_addr_o <= word_i.addr;
        conv_ctl_o  <= word_i.conv;
        stby_bit_q  <= word_i.stby;
        if (!word_i.stby) standby_o <= 1'b0;
      end
      if (stby_edge_i && stby_bit_q) standby_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ctl_wr_port.sv
module ctl_wr_port
  import ctl_wr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              frame_ni,
  input  logic              sdata_i,
  output logic [ADDR_W-1:0] chan_addr_o,
  output logic              conv_ctl_o,
  output logic              standby_o,
  output logic              wr_strobe_o,
  output logic              conv_req_o
);
  logic [2:0] raw, syn;
  ctl_word_t  word;
  logic       commit, stby_edge, abort_conv;

  assign raw = {sdata_i, frame_ni, sclk_i};

  ctl_wr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  ctl_wr_deser u_deser (
    .clk_i, .rst_ni,
    .sclk_i(syn[0]), .frame_ni(syn[1]), .sdata_i(syn[2]),
    .word_o(word), .commit_o(commit), .stby_edge_o(stby_edge),
    .abort_conv_o(abort_conv)
  );

  ctl_wr_regs u_regs (
    .clk_i, .rst_ni,
    .word_i(word), .commit_i(commit), .stby_edge_i(stby_edge),
    .abort_conv_i(abort_conv),
    .chan_addr_o, .conv_ctl_o, .standby_o, .wr_strobe_o, .conv_req_o
  );
endmodule

// File: rtl/ctl_wr_port_chk.sv
module ctl_wr_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] chan_addr_o,
  input logic       conv_ctl_o,
  input logic       standby_o,
  input logic       wr_strobe_o,
  input logic       conv_req_o
);
  a_r3_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !wr_strobe_o);

  a_r7_conv_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);

  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe_o |-> ($stable(chan_addr_o) && $stable(conv_ctl_o)));

  a_r5_standby_not_at_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> !wr_strobe_o);

  a_r6_standby_clear_at_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(standby_o) |-> wr_strobe_o);
endmodule

bind ctl_wr_port ctl_wr_port_chk u_chk (
  .clk_i, .rst_ni, .chan_addr_o, .conv_ctl_o, .standby_o, .wr_strobe_o, .conv_req_o
);

// File: tb/ctl_wr_port_tb_top.sv
module ctl_wr_port_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b1;
  logic       frame_ni = 1'b1;
  logic       sdata_i = 1'b0;
  logic [2:0] chan_addr_o;
  logic       conv_ctl_o, standby_o, wr_strobe_o, conv_req_o;

  int n_chk = 0, n_fail = 0;
  int strobes = 0, convs = 0, exp_strobes = 0, exp_convs = 0;
  logic [4:0] exp_q [$];
  logic [2:0] m_addr = '0;
  logic       m_conv = 1'b0, m_stby = 1'b0;
  logic       prev_strobe = 1'b0;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  ctl_wr_port dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected words as strobes appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (conv_req_o) convs++;
      if (wr_strobe_o) begin
        logic [4:0] e;
        strobes++;
        chk(!prev_strobe, "R3 strobe width", 2, 1);
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected strobe", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(chan_addr_o == e[4:2], "R2 address", chan_addr_o, e[4:2]);
          chk(conv_ctl_o == e[1], "R2 conversion bit", conv_ctl_o, e[1]);
        end
      end
      prev_strobe = wr_strobe_o;
    end
  end

  // driver: d is {A2,A1,A0,CONV,STBY}; n falling edges; fill drives later edges
  task automatic send(input logic [4:0] d, input int n, input logic fill, input string req);
    if (n >= 6) begin
      exp_q.push_back(d);
      exp_strobes++;
      m_addr = d[4:2];
      m_conv = d[1];
      if (!d[0]) m_stby = 1'b0;
      if (n >= 7 && d[0]) m_stby = 1'b1;
      if (d[1]) exp_convs++;
    end else if (n >= 4 && d[1]) exp_convs++;
    frame_ni = 1'b0;
    repeat (4) @(posedge clk_i);
    for (int k = 1; k <= n; k++) begin
      sdata_i = (k <= 5) ? d[5-k] : fill;
      repeat (4) @(posedge clk_i);
      sclk_i = 1'b0;
      repeat (4) @(posedge clk_i);
      sclk_i = 1'b1;
    end
    repeat (4) @(posedge clk_i);
    frame_ni = 1'b1;
    repeat (12) @(posedge clk_i);
    @(negedge clk_i);
    chk(chan_addr_o == m_addr, req, chan_addr_o, m_addr);
    chk(conv_ctl_o == m_conv, req, conv_ctl_o, m_conv);
    chk(standby_o == m_stby, req, standby_o, m_stby);
    chk(strobes == exp_strobes, req, strobes, exp_strobes);
    chk(convs == exp_convs, req, convs, exp_convs);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk({chan_addr_o, conv_ctl_o, standby_o, wr_strobe_o, conv_req_o} == '0, "R1 reset", 
        {chan_addr_o, conv_ctl_o, standby_o, wr_strobe_o, conv_req_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    send(5'b10110, 6, 1'b0, "R3 R7 commit with conversion");
    send(5'b01100, 6, 1'b1, "R2 R7 commit no conversion");
    send(5'b01101, 6, 1'b0, "R5 six edges no standby");
    send(5'b01101, 7, 1'b0, "R5 seventh edge standby");
    send(5'b11111, 3, 1'b0, "R4 abort three edges");
    send(5'b11110, 5, 1'b0, "R8 abort five edges conversion");
    send(5'b11100, 4, 1'b0, "R4 abort four edges no conversion");
    send(5'b11010, 4, 1'b0, "R8 abort four edges conversion");
    send(5'b11111, 2, 1'b0, "R10 short frame before commit");
    send(5'b01000, 10, 1'b1, "R6 R9 clear standby extra edges");
    send(5'b11111, 7, 1'b0, "R5 standby again");
    send(5'b00100, 6, 1'b1, "R6 six edges clear standby");
    send(5'b10001, 9, 1'b0, "R9 late data ignored");
    chk(exp_q.size() == 0, "R3 pending writes", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule